// File: doc/BRIEF.md
# I/O Port Configuration Lock Controller

This block holds the configuration registers of a 16-pin I/O port and can freeze them pin by pin. The port configuration covers six registers: pin mode, output type, output speed, pull selection, and two alternate-function select registers. One register holds the low eight pins and the other holds the high eight. All six are read and written over a simple single-cycle memory-mapped bus with per-byte lane enables. Their contents drive the port's configuration outputs directly from flip-flops.

A seventh register, the lock register, has a key bit and a 16-bit pin mask. Software freezes a set of pins with a fixed five-step sequence. Every step must be a full-word access, and every write step must carry the same mask. A wrong step puts the sequence back to its start. Once the sequence completes, the selected pins' fields in all six configuration registers stop accepting writes until the next reset. Fields of pins outside the mask stay writable. The lock register itself then becomes read-only.

Top module: `port_cfg_lock`

## Requirements
- R1: After synchronous reset (`rst` high), all six configuration registers, the lock register and `bus_rdata` read 0, and no pin is frozen.
- R2: Word addresses are 0 mode (2 bits per pin), 1 output type (1 bit per pin, bits 15:0), 2 speed (2 bits per pin), 3 pull (2 bits per pin), 4 alternate function for pins 0-7 (4 bits per pin), 5 alternate function for pins 8-15 (pin 8+k at bits 4k+3:4k), and 6 lock. Pin i occupies bits FW*i+FW-1:FW*i. A write updates only the bytes whose `bus_be` bit is set. Unused bits read 0. A read returns data in `bus_rdata` on the clock edge after the access.
- R3: The lock register holds the key in bit 16 and the mask in bits 15:0. The lock sequence is: write key=1, write key=0, write key=1, read, read. The first read returns key 0. The second read returns key 1 with the mask, and from the next cycle the masked pins are frozen.
- R4: A write step whose mask differs from the mask of the previous write aborts the sequence to its start.
- R5: Any lock-register access with `bus_be` other than 4'b1111 aborts the sequence.
- R6: A lock-register access of the wrong kind for the current step aborts the sequence, for example a read while a write is expected.
- R7: When pin i is frozen, writes to any of the six configuration registers leave pin i's field unchanged. The same write still updates the fields of unfrozen pins.
- R8: After the lock completes, the lock register reads key 1 with the locked mask, and writes to it have no effect.
- R9: Only reset clears the lock. After reset, all pins are writable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cfg_mode | output | 32 | Pin mode fields |
| cfg_otype | output | 16 | Output type bits |
| cfg_speed | output | 32 | Output speed fields |
| cfg_pull | output | 32 | Pull selection fields |
| cfg_af_lo | output | 32 | Alternate function, pins 0-7 |
| cfg_af_hi | output | 32 | Alternate function, pins 8-15 |

## Verification
Byte-lane masking and pin freezing both act on a single configuration write. After a lock with the irregular mask 16'hA5C3, every register is written with full and partial lane enables. The expected value is computed in the bench as the intersection of enabled lanes and unfrozen pins. The bench also issues configuration writes in the cycles that follow the confirming read, where the freeze first takes effect. The sequence is broken at several points by a mask change, a narrow access and a premature read. Each broken sequence must leave the key at 0 and the port fully writable.

// File: rtl/plk_pkg.sv
package plk_pkg;
  localparam int DW = 32;
  localparam logic [2:0] A_MODE  = 3'd0;
  localparam logic [2:0] A_OTYPE = 3'd1;
  localparam logic [2:0] A_SPEED = 3'd2;
  localparam logic [2:0] A_PULL  = 3'd3;
  localparam logic [2:0] A_AFLO  = 3'd4;
  localparam logic [2:0] A_AFHI  = 3'd5;
  localparam logic [2:0] A_LOCK  = 3'd6;

  typedef enum logic [2:0] {
    LK_IDLE, LK_W1, LK_W2, LK_W3, LK_R1, LK_DONE
  } lck_state_t;
endpackage

// File: rtl/plk_lock_seq.sv
module plk_lock_seq
  import plk_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc,
  input  logic            wr,
  input  logic            full,
  input  logic [PINS:0]   wdata,
  output logic [PINS-1:0] mask_q,
  output lck_state_t      state_q,
  output logic            key_rd
);
  lck_state_t nxt;
  logic       same;
  logic       key_in;

  assign same   = (wdata[PINS-1:0] == mask_q);
  assign key_in = wdata[PINS];

  always_comb begin
    nxt = state_q;
    if (acc && state_q != LK_DONE) begin
      nxt = LK_IDLE;
      if (full) begin
        case (state_q)
          LK_IDLE: if (wr && key_in)          nxt = LK_W1;
          LK_W1:   if (wr && !key_in && same) nxt = LK_W2;
          LK_W2:   if (wr && key_in && same)  nxt = LK_W3;
          LK_W3:   if (!wr)                   nxt = LK_R1;
          LK_R1:   if (!wr)                   nxt = LK_DONE;
          default:                            nxt = LK_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LK_IDLE;
      mask_q  <= '0;
    end else begin
      state_q <= nxt;
      if (acc && wr && full && state_q != LK_DONE)
        mask_q <= wdata[PINS-1:0];
    end
  end

  assign key_rd = (state_q == LK_R1) || (state_q == LK_DONE);

  // R8
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == LK_DONE) |=> (state_q == LK_DONE && $stable(mask_q)));

  // R5
  narrow_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !full && state_q != LK_DONE) |=> (state_q == LK_IDLE));

  // R4
  mismatch_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && wr && full && (state_q == LK_W1 || state_q == LK_W2) &&
     wdata[PINS-1:0] != mask_q) |=> (state_q == LK_IDLE));
endmodule

// File: rtl/plk_cfg_bank.sv
module plk_cfg_bank #(
  parameter int PINS = 16,
  parameter int FW   = 2,
  parameter int NF   = 16,
  parameter int PIN0 = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  input  logic [PINS-1:0]  frozen,
  output logic [NF*FW-1:0] q
);
  for (genvar f = 0; f < NF; f++) begin : g_field
    localparam int LANE = (f * FW) / 8;
    localparam int PIN  = PIN0 + f;

    always_ff @(posedge clk) begin
      if (rst)
        q[f*FW +: FW] <= '0;
      else if (we && be[LANE] && !frozen[PIN])
        q[f*FW +: FW] <= wdata[f*FW +: FW];
    end

    // R7
    frozen_field_chk: assert property (@(posedge clk) disable iff (rst)
      frozen[PIN] |=> $stable(q[f*FW +: FW]));
  end
endmodule

// File: rtl/port_cfg_lock.sv
module port_cfg_lock
  import plk_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int MODE_W = 2,
  parameter int AF_W   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [PINS*MODE_W-1:0] cfg_mode,
  output logic [PINS-1:0]        cfg_otype,
  output logic [PINS*MODE_W-1:0] cfg_speed,
  output logic [PINS*MODE_W-1:0] cfg_pull,
  output logic [PINS/2*AF_W-1:0] cfg_af_lo,
  output logic [PINS/2*AF_W-1:0] cfg_af_hi
);
  localparam int HALF = PINS / 2;

  logic            full;
  logic            lock_acc;
  logic [PINS-1:0] mask_q;
  logic [PINS-1:0] frozen;
  logic            key_rd;
  lck_state_t      lk_state;

  assign full     = (bus_be == 4'b1111);
  assign lock_acc = bus_sel && (bus_addr == A_LOCK);

  plk_lock_seq #(.PINS(PINS)) u_seq (
    .clk(clk), .rst(rst), .acc(lock_acc), .wr(bus_wr), .full(full),
    .wdata(bus_wdata[PINS:0]), .mask_q(mask_q), .state_q(lk_state),
    .key_rd(key_rd)
  );

  assign frozen = (lk_state == LK_DONE) ? mask_q : '0;

  function automatic logic wsel(input logic [2:0] a);
    return bus_sel && bus_wr && (bus_addr == a);
  endfunction

  plk_cfg_bank #(.PINS(PINS), .FW(MODE_W), .NF(PINS), .PIN0(0)) u_mode (
    .clk(clk), .rst(rst), .we(wsel(A_MODE)), .be(bus_be), .wdata(bus_wdata),
    .frozen(frozen), .q(cfg_mode));
  plk_cfg_bank #(.PINS(PINS), .FW(1), .NF(PINS), .PIN0(0)) u_otype (
    .clk(clk), .rst(rst), .we(wsel(A_OTYPE)), .be(bus_be), .wdata(bus_wdata),
    .frozen(frozen), .q(cfg_otype));
  plk_cfg_bank #(.PINS(PINS), .FW(MODE_W), .NF(PINS), .PIN0(0)) u_speed (
    .clk(clk), .rst(rst), .we(wsel(A_SPEED)), .be(bus_be), .wdata(bus_wdata),
    .frozen(frozen), .q(cfg_speed));
  plk_cfg_bank #(.PINS(PINS), .FW(MODE_W), .NF(PINS), .PIN0(0)) u_pull (
    .clk(clk), .rst(rst), .we(wsel(A_PULL)), .be(bus_be), .wdata(bus_wdata),
    .frozen(frozen), .q(cfg_pull));
  plk_cfg_bank #(.PINS(PINS), .FW(AF_W), .NF(HALF), .PIN0(0)) u_aflo (
    .clk(clk), .rst(rst), .we(wsel(A_AFLO)), .be(bus_be), .wdata(bus_wdata),
    .frozen(frozen), .q(cfg_af_lo));
  plk_cfg_bank #(.PINS(PINS), .FW(AF_W), .NF(HALF), .PIN0(HALF)) u_afhi (
    .clk(clk), .rst(rst), .we(wsel(A_AFHI)), .be(bus_be), .wdata(bus_wdata),
    .frozen(frozen), .q(cfg_af_hi));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_MODE:  bus_rdata <= DW'(cfg_mode);
        A_OTYPE: bus_rdata <= DW'(cfg_otype);
        A_SPEED: bus_rdata <= DW'(cfg_speed);
        A_PULL:  bus_rdata <= DW'(cfg_pull);
        A_AFLO:  bus_rdata <= DW'(cfg_af_lo);
        A_AFHI:  bus_rdata <= DW'(cfg_af_hi);
        A_LOCK:  bus_rdata <= DW'({key_rd, mask_q});
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R3
  confirm_key_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_acc && !bus_wr && full && lk_state == LK_R1) |=> bus_rdata[PINS]);

  // R3
  early_key_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_acc && !bus_wr && lk_state != LK_R1 && lk_state != LK_DONE)
      |=> !bus_rdata[PINS]);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (lk_state == LK_IDLE && bus_rdata == '0));
endmodule

// File: tb/test_port_cfg_lock.sv
`timescale 1ns/100ps
module test_port_cfg_lock;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] cfg_mode, cfg_speed, cfg_pull, cfg_af_lo, cfg_af_hi;
  logic [15:0] cfg_otype;

  int checks = 0;
  int errors = 0;
  logic [31:0] m [0:5];
  logic [15:0] fz;

  always #2.5 clk = ~clk;

  port_cfg_lock i_port_cfg_lock (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cfg_mode(cfg_mode), .cfg_otype(cfg_otype),
    .cfg_speed(cfg_speed), .cfg_pull(cfg_pull), .cfg_af_lo(cfg_af_lo),
    .cfg_af_hi(cfg_af_hi)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // bits of register a that a write with enables be may change, given frozen pins
  function automatic logic [31:0] upd(input int a, input logic [3:0] be, input logic [15:0] f);
    logic [31:0] u = '0;
    int fw   = (a == 1) ? 1 : ((a >= 4) ? 4 : 2);
    int base = (a == 5) ? 8 : 0;
    int nb   = (a == 1) ? 16 : 32;
    for (int b = 0; b < nb; b++)
      u[b] = be[b/8] && !f[base + b/fw];
    return u;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic cfg_wr(input int a, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] u = upd(a, be, fz);
    wr(3'(a), be, d);
    m[a] = (m[a] & ~u) | (d & u);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) m[i] = '0;
    fz = '0;
  endtask

  function automatic logic [31:0] lkw(input logic key, input logic [15:0] msk);
    return {15'b0, key, msk};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] M;
    M = 16'hA5C3;
    do_reset();

    // R1: reset state
    chk("R1 rdata", bus_rdata, 32'h0);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), 4'hF, d);
      chk("R1 reg", d, 32'h0);
    end
    chk("R1 otype out", {16'h0, cfg_otype}, 32'h0);

    // R2: full byte-enable sweep on every configuration register
    for (int a = 0; a < 6; a++)
      for (int be = 0; be < 16; be++) begin
        cfg_wr(a, 4'(be), 32'h9E3779B9 ^ (32'(a) * 32'h01010101) ^ (32'(be) << 4));
        rd(3'(a), 4'hF, d);
        chk("R2 readback", d, m[a]);
      end
    chk("R2 mode out", cfg_mode, m[0]);
    chk("R2 otype out", {16'h0, cfg_otype}, m[1]);
    chk("R2 afhi out", cfg_af_hi, m[5]);

    // R4: mask changes mid-sequence
    wr(3'd6, 4'hF, lkw(1, M));
    wr(3'd6, 4'hF, lkw(0, M ^ 16'h0001));
    wr(3'd6, 4'hF, lkw(1, M ^ 16'h0001));
    rd(3'd6, 4'hF, d);
    rd(3'd6, 4'hF, d);
    chk("R4 key after mismatch", {31'b0, d[16]}, 32'h0);
    cfg_wr(0, 4'hF, 32'hFFFFFFFF);
    rd(3'd0, 4'hF, d);
    chk("R4 still writable", d, 32'hFFFFFFFF);

    // R5: narrow access in the middle
    wr(3'd6, 4'hF, lkw(1, M));
    wr(3'd6, 4'h7, lkw(0, M));
    wr(3'd6, 4'hF, lkw(1, M));
    rd(3'd6, 4'hF, d);
    rd(3'd6, 4'hF, d);
    chk("R5 key after narrow", {31'b0, d[16]}, 32'h0);
    cfg_wr(1, 4'hF, 32'h0000FFFF);
    rd(3'd1, 4'hF, d);
    chk("R5 still writable", d, 32'h0000FFFF);

    // R6: premature read
    wr(3'd6, 4'hF, lkw(1, M));
    rd(3'd6, 4'hF, d);
    wr(3'd6, 4'hF, lkw(0, M));
    wr(3'd6, 4'hF, lkw(1, M));
    rd(3'd6, 4'hF, d);
    rd(3'd6, 4'hF, d);
    chk("R6 key after bad order", {31'b0, d[16]}, 32'h0);

    // R3: valid sequence
    wr(3'd6, 4'hF, lkw(1, M));
    wr(3'd6, 4'hF, lkw(0, M));
    wr(3'd6, 4'hF, lkw(1, M));
    rd(3'd6, 4'hF, d);
    chk("R3 first read key 0", {31'b0, d[16]}, 32'h0);
    rd(3'd6, 4'hF, d);
    chk("R3 confirm read", d, lkw(1, M));
    fz = M;

    // R7: per-pin freezing combined with byte lanes
    for (int a = 0; a < 6; a++)
      foreach (m[k]) begin
        logic [3:0] bes [0:5] = '{4'hF, 4'h5, 4'hA, 4'h3, 4'hC, 4'hF};
        cfg_wr(a, bes[k], ~m[a] ^ (32'(k) * 32'h11111111));
        rd(3'(a), 4'hF, d);
        chk("R7 frozen readback", d, m[a]);
      end
    chk("R7 pull out", cfg_pull, m[3]);
    chk("R7 aflo out", cfg_af_lo, m[4]);

    // R8: lock register read-only after lock
    wr(3'd6, 4'hF, 32'h0);
    rd(3'd6, 4'hF, d);
    chk("R8 write ignored", d, lkw(1, M));
    wr(3'd6, 4'hF, lkw(1, 16'hFFFF));
    wr(3'd6, 4'hF, lkw(0, 16'hFFFF));
    wr(3'd6, 4'hF, lkw(1, 16'hFFFF));
    rd(3'd6, 4'hF, d);
    rd(3'd6, 4'hF, d);
    chk("R8 relock ignored", d, lkw(1, M));
    cfg_wr(2, 4'hF, ~m[2]);
    rd(3'd2, 4'hF, d);
    chk("R8 old mask kept", d, m[2]);

    // R9: reset clears lock
    do_reset();
    rd(3'd6, 4'hF, d);
    chk("R9 lock cleared", d, 32'h0);
    cfg_wr(0, 4'hF, 32'hFFFFFFFF);
    rd(3'd0, 4'hF, d);
    chk("R9 writable again", d, 32'hFFFFFFFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule